// File: doc/BRIEF.md
# Interrupt Entry and Status Restore Controller

This controller decides when a small processor core enters an interrupt routine and keeps the status that must come back when the routine ends. Two sources can interrupt: an external request line and a timer overflow. Each source has its own enable and disable strobes. A timer overflow is remembered as pending until it is served or timer interrupts are turned off. At an instruction boundary the controller takes the highest-priority enabled request, unless a routine is already in service. Taking an interrupt behaves like a subroutine call that saves status.

Status is handled as a 4-bit nibble: three arithmetic and user flags plus the working register bank select. On a call or a taken interrupt the controller presents the nibble to be pushed alongside the return address. The return-address stack itself and the vector fetch are outside this block. On a return-and-restore it takes the popped nibble, reports it to the core, reloads the register bank from it and ends interrupt service. A plain return changes none of this state.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset both sources are disabled, no routine is in service, the register bank is 0 and every pulse output (take_o, save_stb_o, rst_vld_o) is low.
- R2: ext_en_i / ext_dis_i and tmr_en_i / tmr_dis_i set and clear the enable of their own source. When enable and disable arrive in the same cycle, disable wins. A request from a disabled source is never taken.
- R3: An interrupt is taken only in a cycle where boundary_i is high. take_o then pulses high for one cycle on the next clock, and in_svc_o goes high in that same cycle.
- R4: When both sources are eligible in the same boundary cycle, the external one is taken. take_src_o is 0 for external and 1 for timer, valid while take_o is high.
- R5: A tmr_ovf_i pulse while the timer is enabled makes a timer request pending. The request stays pending over any number of cycles until it is taken or tmr_dis_i is applied. Taking it clears it.
- R6: While in_svc_o is high no interrupt is taken, whatever the enables and requests.
- R7: On call_i or a taken interrupt, save_stb_o pulses on the next clock. save_nib_o then carries {flags_i[2:0], bank} (bank at bit 0) as they were in the call or boundary cycle.
- R8: ret_i alone leaves in_svc_o and bank_o unchanged and produces no rst_vld_o pulse.
- R9: On retr_i, rst_vld_o pulses on the next clock with rst_nib_o equal to pop_nib_i. bank_o takes pop_nib_i[0] and in_svc_o clears.
- R10: bank_sel_i loads bank_o with bank_val_i on the next clock. A same-cycle retr_i takes priority, and the bank then comes from pop_nib_i[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary, the only point where interrupts are taken |
| ext_req_i | input | 1 | External interrupt request level |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ext_en_i | input | 1 | Enable external interrupts |
| ext_dis_i | input | 1 | Disable external interrupts |
| tmr_en_i | input | 1 | Enable timer interrupts |
| tmr_dis_i | input | 1 | Disable timer interrupts and drop a pending request |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Plain return strobe |
| retr_i | input | 1 | Return-and-restore strobe |
| bank_sel_i | input | 1 | Register bank switch request |
| bank_val_i | input | 1 | Bank to select |
| flags_i | input | 3 | Current flags {carry, aux carry, user flag} |
| pop_nib_i | input | 4 | Nibble popped from the stack on return-and-restore |
| take_o | output | 1 | One-cycle pulse: interrupt taken |
| take_src_o | output | 1 | Taken source, 0 external, 1 timer |
| in_svc_o | output | 1 | Interrupt routine in service |
| save_stb_o | output | 1 | One-cycle pulse: push save_nib_o |
| save_nib_o | output | 4 | Status nibble to save |
| rst_vld_o | output | 1 | One-cycle pulse: rst_nib_o restored |
| rst_nib_o | output | 4 | Restored status nibble |
| bank_o | output | 1 | Active working register bank |

## Verification
Every result is registered exactly once. take_o, take_src_o, in_svc_o, save_stb_o, save_nib_o, rst_vld_o, rst_nib_o and bank_o all change on the first clock edge after the cycle that holds the stimulus. The bench drives each input set one nanosecond after a rising edge and reads the outputs one nanosecond after the following edge, so each check sees the response to exactly one cycle of stimulus. A sweep of every enable pair against every request pair compares the taken flag and source with values worked out arithmetically in the bench. Enables and pending state, which have no output of their own, are observed through whether a later boundary produces a take.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_TMR = 1'b1
  } irq_src_e;

  localparam int unsigned N_SRC = 2;
endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_en_i,
  input  logic ext_dis_i,
  input  logic tmr_en_i,
  input  logic tmr_dis_i,
  input  logic tmr_ovf_i,
  input  logic tmr_taken_i,
  output logic ext_on_o,
  output logic tmr_on_o,
  output logic tmr_pend_o
);
  logic ext_on_q, ext_on_d;
  logic tmr_on_q, tmr_on_d;
  logic pend_q, pend_d;

  always_comb begin
    ext_on_d = ext_on_q;
    if (ext_dis_i)     ext_on_d = 1'b0;
    else if (ext_en_i) ext_on_d = 1'b1;

    tmr_on_d = tmr_on_q;
    if (tmr_dis_i)     tmr_on_d = 1'b0;
    else if (tmr_en_i) tmr_on_d = 1'b1;

    pend_d = tmr_on_d & ((pend_q & ~tmr_taken_i) | tmr_ovf_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_on_q <= 1'b0;
      tmr_on_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      ext_on_q <= ext_on_d;
      tmr_on_q <= tmr_on_d;
      pend_q   <= pend_d;
    end
  end

  assign ext_on_o   = ext_on_q;
  assign tmr_on_o   = tmr_on_q;
  assign tmr_pend_o = pend_q;

  a_r2_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ext_dis_i |=> !ext_on_o);
  a_r5_pend_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_dis_i |=> !tmr_pend_o);
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] req_i,
  input  logic         open_i,
  output logic         fire_o,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0] raw_gnt;

  assign raw_gnt[0] = req_i[0];
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign raw_gnt[i] = req_i[i] & ~(|req_i[i-1:0]);
  end

  assign fire_o = open_i & (|req_i);
  assign gnt_o  = open_i ? raw_gnt : '0;
endmodule

// File: rtl/irq_status_keep.sv
module irq_status_keep #(
  parameter int unsigned FLAG_W = 3,
  parameter int unsigned BANK_W = 1,
  localparam int unsigned NIB_W = FLAG_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              call_i,
  input  logic              retr_i,
  input  logic              bank_sel_i,
  input  logic [BANK_W-1:0] bank_val_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [NIB_W-1:0]  pop_nib_i,
  output logic              in_svc_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              save_stb_o,
  output logic [NIB_W-1:0]  save_nib_o,
  output logic              rst_vld_o,
  output logic [NIB_W-1:0]  rst_nib_o
);
  logic              svc_q, svc_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              save_stb_q, save_stb_d;
  logic [NIB_W-1:0]  save_nib_q;
  logic              rst_vld_q;
  logic [NIB_W-1:0]  rst_nib_q;

  always_comb begin
    svc_d = svc_q;
    if (fire_i)      svc_d = 1'b1;
    else if (retr_i) svc_d = 1'b0;

    bank_d = bank_q;
    if (retr_i)          bank_d = pop_nib_i[BANK_W-1:0];
    else if (bank_sel_i) bank_d = bank_val_i;

    save_stb_d = call_i | fire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q      <= 1'b0;
      bank_q     <= '0;
      save_stb_q <= 1'b0;
      save_nib_q <= '0;
      rst_vld_q  <= 1'b0;
      rst_nib_q  <= '0;
    end else begin
      svc_q      <= svc_d;
      bank_q     <= bank_d;
      save_stb_q <= save_stb_d;
      rst_vld_q  <= retr_i;
      if (save_stb_d) save_nib_q <= {flags_i, bank_q};
      if (retr_i)     rst_nib_q  <= pop_nib_i;
    end
  end

  assign in_svc_o   = svc_q;
  assign bank_o     = bank_q;
  assign save_stb_o = save_stb_q;
  assign save_nib_o = save_nib_q;
  assign rst_vld_o  = rst_vld_q;
  assign rst_nib_o  = rst_nib_q;

  a_r7_save_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i || fire_i) |=> save_stb_o && (save_nib_o == $past({flags_i, bank_o})));
  a_r9_restore_ends_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (retr_i && !fire_i) |=> rst_vld_o && !in_svc_o && (rst_nib_o == $past(pop_nib_i)));
  a_r10_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel_i && !retr_i) |=> bank_o == $past(bank_val_i));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary_i,
  input  logic       ext_req_i,
  input  logic       tmr_ovf_i,
  input  logic       ext_en_i,
  input  logic       ext_dis_i,
  input  logic       tmr_en_i,
  input  logic       tmr_dis_i,
  input  logic       call_i,
  input  logic       ret_i,
  input  logic       retr_i,
  input  logic       bank_sel_i,
  input  logic       bank_val_i,
  input  logic [2:0] flags_i,
  input  logic [3:0] pop_nib_i,
  output logic       take_o,
  output logic       take_src_o,
  output logic       in_svc_o,
  output logic       save_stb_o,
  output logic [3:0] save_nib_o,
  output logic       rst_vld_o,
  output logic [3:0] rst_nib_o,
  output logic       bank_o
);
  import irq_ctrl_pkg::*;

  logic             ext_on, tmr_on, tmr_pend;
  logic [N_SRC-1:0] req, gnt;
  logic             fire;
  irq_src_e         src_d, src_q;
  logic             take_q;
  logic             tmr_taken;

  irq_src_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_en_i    (ext_en_i),
    .ext_dis_i   (ext_dis_i),
    .tmr_en_i    (tmr_en_i),
    .tmr_dis_i   (tmr_dis_i),
    .tmr_ovf_i   (tmr_ovf_i),
    .tmr_taken_i (tmr_taken),
    .ext_on_o    (ext_on),
    .tmr_on_o    (tmr_on),
    .tmr_pend_o  (tmr_pend)
  );

  assign req[SRC_EXT] = ext_req_i & ext_on;
  assign req[SRC_TMR] = tmr_pend & tmr_on;

  irq_prio #(.N(N_SRC)) u_prio (
    .req_i  (req),
    .open_i (boundary_i & ~in_svc_o),
    .fire_o (fire),
    .gnt_o  (gnt)
  );

  assign src_d     = gnt[SRC_TMR] ? SRC_TMR : SRC_EXT;
  assign tmr_taken = fire & (src_d == SRC_TMR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      src_q  <= SRC_EXT;
    end else begin
      take_q <= fire;
      if (fire) src_q <= src_d;
    end
  end

  irq_status_keep #(.FLAG_W(3), .BANK_W(1)) u_keep (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (fire),
    .call_i     (call_i),
    .retr_i     (retr_i),
    .bank_sel_i (bank_sel_i),
    .bank_val_i (bank_val_i),
    .flags_i    (flags_i),
    .pop_nib_i  (pop_nib_i),
    .in_svc_o   (in_svc_o),
    .bank_o     (bank_o),
    .save_stb_o (save_stb_o),
    .save_nib_o (save_nib_o),
    .rst_vld_o  (rst_vld_o),
    .rst_nib_o  (rst_nib_o)
  );

  assign take_o     = take_q;
  assign take_src_o = src_q;

  a_r3_take_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));
  a_r6_blocked_in_svc: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !$past(in_svc_o));
  a_r4_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && $past(ext_req_i && ext_on)) |-> (take_src_o == SRC_EXT));
  a_r8_plain_ret_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !retr_i && !bank_sel_i) |=> $stable(bank_o) && !rst_vld_o);
endmodule

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       boundary_i, ext_req_i, tmr_ovf_i, ext_en_i, ext_dis_i;
  logic       tmr_en_i, tmr_dis_i, call_i, ret_i, retr_i, bank_sel_i, bank_val_i;
  logic [2:0] flags_i;
  logic [3:0] pop_nib_i;
  logic       take_o, take_src_o, in_svc_o, save_stb_o, rst_vld_o, bank_o;
  logic [3:0] save_nib_o, rst_nib_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ext_req_i(ext_req_i),
    .tmr_ovf_i(tmr_ovf_i), .ext_en_i(ext_en_i), .ext_dis_i(ext_dis_i),
    .tmr_en_i(tmr_en_i), .tmr_dis_i(tmr_dis_i), .call_i(call_i), .ret_i(ret_i),
    .retr_i(retr_i), .bank_sel_i(bank_sel_i), .bank_val_i(bank_val_i),
    .flags_i(flags_i), .pop_nib_i(pop_nib_i), .take_o(take_o),
    .take_src_o(take_src_o), .in_svc_o(in_svc_o), .save_stb_o(save_stb_o),
    .save_nib_o(save_nib_o), .rst_vld_o(rst_vld_o), .rst_nib_o(rst_nib_o),
    .bank_o(bank_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    boundary_i = 0; ext_req_i = 0; tmr_ovf_i = 0; ext_en_i = 0; ext_dis_i = 0;
    tmr_en_i = 0; tmr_dis_i = 0; call_i = 0; ret_i = 0; retr_i = 0;
    bank_sel_i = 0; bank_val_i = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    idle();
    flags_i = 0; pop_nib_i = 0;
    rst_n = 0;
    repeat (3) tick();
    // R1: reset state
    chk("R1 take", take_o, 0);
    chk("R1 in_svc", in_svc_o, 0);
    chk("R1 bank", bank_o, 0);
    chk("R1 save_stb", save_stb_o, 0);
    chk("R1 rst_vld", rst_vld_o, 0);
    rst_n = 1;
    tick();

    // R1/R2: sources disabled after reset, request ignored
    ext_req_i = 1; boundary_i = 1;
    tick();
    chk("R2 disabled after reset, no take", take_o, 0);
    chk("R2 no service", in_svc_o, 0);
    idle();

    // R2 R3 R4 R5 R7: sweep enables x requests
    for (int e = 0; e < 4; e++) begin
      for (int r = 0; r < 4; r++) begin
        logic exp_take, exp_src;
        logic [2:0] fl;
        fl = 3'((e * 4 + r) % 8);
        exp_take = (e[0] & r[0]) | (e[1] & r[1]);
        exp_src  = !(e[0] & r[0]);
        ext_en_i = e[0]; tmr_en_i = e[1];
        tick();
        idle();
        tmr_ovf_i = r[1];
        tick();
        idle();
        ext_req_i = r[0]; boundary_i = 1; flags_i = fl;
        tick();
        idle();
        chk($sformatf("R2 R5 take e=%0d r=%0d", e, r), take_o, exp_take);
        chk("R3 in_svc follows take", in_svc_o, exp_take);
        chk("R7 save strobe on take", save_stb_o, exp_take);
        if (exp_take) begin
          chk("R4 source", take_src_o, exp_src);
          chk("R7 saved nibble", save_nib_o, {fl, 1'b0});
          retr_i = 1; pop_nib_i = 4'b0000;
          tick();
          idle();
          chk("R9 service ends", in_svc_o, 0);
        end
        ext_dis_i = 1; tmr_dis_i = 1;
        tick();
        idle();
      end
    end

    // R3: no boundary, no take
    ext_en_i = 1;
    tick();
    idle();
    ext_req_i = 1;
    repeat (3) tick();
    chk("R3 no take without boundary", take_o, 0);
    boundary_i = 1;
    tick();
    chk("R3 take at boundary", take_o, 1);
    chk("R3 in_svc set", in_svc_o, 1);
    tick();
    chk("R3 take is one cycle", take_o, 0);
    chk("R6 blocked while in service", in_svc_o, 1);
    repeat (3) tick();
    chk("R6 still no take", take_o, 0);
    idle();

    // R8: plain return keeps state
    ret_i = 1;
    tick();
    idle();
    chk("R8 in_svc kept", in_svc_o, 1);
    chk("R8 bank kept", bank_o, 0);
    chk("R8 no restore pulse", rst_vld_o, 0);

    // R10: bank switch inside routine
    bank_sel_i = 1; bank_val_i = 1;
    tick();
    idle();
    chk("R10 bank switched", bank_o, 1);
    ret_i = 1;
    tick();
    idle();
    chk("R8 bank kept after switch", bank_o, 1);

    // R9: restore
    retr_i = 1; pop_nib_i = 4'b1010;
    tick();
    idle();
    chk("R9 restore pulse", rst_vld_o, 1);
    chk("R9 restored nibble", rst_nib_o, 4'b1010);
    chk("R9 bank back", bank_o, 0);
    chk("R9 service over", in_svc_o, 0);
    tick();
    chk("R9 restore pulse one cycle", rst_vld_o, 0);
    ext_dis_i = 1;
    tick();
    idle();

    // R5: pending holds until taken
    tmr_en_i = 1;
    tick();
    idle();
    tmr_ovf_i = 1;
    tick();
    idle();
    repeat (5) tick();
    boundary_i = 1;
    tick();
    idle();
    chk("R5 held request taken", take_o, 1);
    chk("R4 timer source", take_src_o, 1);
    retr_i = 1; pop_nib_i = 0;
    tick();
    idle();
    boundary_i = 1;
    tick();
    idle();
    chk("R5 pending cleared by take", take_o, 0);
    tmr_ovf_i = 1;
    tick();
    idle();
    tmr_dis_i = 1;
    tick();
    idle();
    tmr_en_i = 1;
    tick();
    idle();
    boundary_i = 1;
    tick();
    idle();
    chk("R5 pending cleared by disable", take_o, 0);
    tmr_dis_i = 1;
    tick();
    idle();

    // R2: enable and disable together -> disabled
    ext_en_i = 1; ext_dis_i = 1;
    tick();
    idle();
    ext_req_i = 1; boundary_i = 1;
    tick();
    idle();
    chk("R2 disable wins", take_o, 0);

    // R7: call saves flags and bank
    bank_sel_i = 1; bank_val_i = 1;
    tick();
    idle();
    call_i = 1; flags_i = 3'b101;
    tick();
    idle();
    chk("R7 call strobe", save_stb_o, 1);
    chk("R7 call nibble", save_nib_o, 4'b1011);
    chk("R7 call not service", in_svc_o, 0);

    // R10: return-and-restore beats bank switch
    retr_i = 1; pop_nib_i = 4'b0110; bank_sel_i = 1; bank_val_i = 1;
    tick();
    idle();
    chk("R10 restore priority on bank", bank_o, 0);
    chk("R9 nibble", rst_nib_o, 4'b0110);

    done = 1'b1;
    finish_run();
  end
endmodule